// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

A synthesizable behavioural model of a word-wide static memory with an asynchronous-style control interface. It has an address, active-low chip select, output enable and write enable, and one active-low enable for each byte lane. The lower lane enable governs data bits 7:0 and the upper lane enable governs bits 15:8. The bidirectional data bus is split into a data-in bus, a data-out bus and a drive flag for each lane. A fast internal clock samples every control, address and data input. The model can therefore find the moment at which a write ends.

A lane is written while chip select, write enable and that lane's enable are all low. The lane takes the data and the address present in the last sampled cycle of that overlap. It commits them when the first of the three signals goes high. Nothing is stored while the window is still open. Each lane keeps its own window, so one lane can close before the other. A read drives only the lanes whose enable is low. The model reports standby when chip select is high, or when both lane enables are high. The storage needs no refresh. The depth is set by `ADDR_W`: the default of 10 keeps elaboration small, and 17 gives the full 131072 words.

Top module: `sram_byte_lane`

## Requirements
- R1: The storage holds 2^ADDR_W independent 16-bit words. A word written with both lanes enabled reads back unchanged, whatever is written at any other address.
- R2: `standby_o` is 1 exactly when the last sampled `ce_ni` is 1, or when both `lb_ni` and `ub_ni` are 1. While `standby_o` is 1, `drive_o` is 2'b00. After reset, `standby_o` is 1.
- R3: Lane 0 (bits 7:0, enabled by `lb_ni`) and lane 1 (bits 15:8, enabled by `ub_ni`) are written on their own. A lane whose enable stays high through a write keeps its old contents.
- R4: A lane commits the data and the address sampled in the last cycle of its window, where the window is `ce_ni`=0, `we_ni`=0 and that lane's enable at 0. Data or addresses present earlier in the same window are not stored.
- R5: A write ends when `we_ni` rises, when `ce_ni` rises, or when the lane's own enable rises. A lane enable that rises ends only that lane's write.
- R6: With `ce_ni`=0, `oe_ni`=0 and `we_ni`=1, `drive_o[k]` is 1 for each lane whose enable is 0. That lane of `data_o` then carries the stored byte. Any lane not driven reads 0 on `data_o`. Outputs reflect the inputs sampled at the previous clock edge.
- R7: While `oe_ni`=1, `drive_o` is 2'b00.
- R8: While `we_ni`=0, `drive_o` is 2'b00, whatever the value of `oe_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| lb_ni | input | 1 | Lane 0 (bits 7:0) enable, active low |
| ub_ni | input | 1 | Lane 1 (bits 15:8) enable, active low |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data; undriven lanes read 0 |
| drive_o | output | 2 | Per-lane output drive flag (bit 0 = lower lane) |
| standby_o | output | 1 | Standby indication |

## Verification
The bench changes the data and then the address while a write window is still open. A model that writes continuously, or that latches at the opening edge, would store the earlier value or corrupt the earlier address. It also closes the upper lane first, changes the data, and then closes the lower lane with write enable. A design that shares one window between the lanes would put the same data in both bytes. Further cases end writes by each of the three signals, open a window with output enable low to show the bus stays undriven, and decode standby with both lane enables high. Random reads and writes over all lane masks are checked against a bench model of the storage.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic             ce_n;
    logic             oe_n;
    logic             we_n;
    logic [LANES-1:0] be_n;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, be_n: '1};
endpackage

// File: rtl/sram_bl_sampler.sv
module sram_bl_sampler
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_IDLE;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      ctrl_o <= ctrl_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/sram_bl_write_ctl.sv
module sram_bl_write_ctl
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  be_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [LANES-1:0]  wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [LANES-1:0]  win, win_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign win[g]     = ~ce_ni & ~we_ni & ~be_ni[g];
    // commit on the closing edge of this lane's window
    assign wr_en_o[g] = win_q[g] & ~win[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      win_q  <= win;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/sram_bl_array.sv
module sram_bl_array
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i[g]) mem[wr_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = mem[rd_addr_i];
  end
endmodule

// File: rtl/sram_bl_read_ctl.sv
module sram_bl_read_ctl
  import sram_bl_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  drive_o,
  output logic              standby_o
);
  logic rd_mode;

  assign rd_mode   = ~ctrl_i.ce_n & ~ctrl_i.oe_n & ctrl_i.we_n;
  assign standby_o = ctrl_i.ce_n | (&ctrl_i.be_n);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign drive_o[g] = rd_mode & ~ctrl_i.be_n[g];
    assign data_o[g*LANE_W +: LANE_W] =
      drive_o[g] ? rd_data_i[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              lb_ni,
  input  logic              ub_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  drive_o,
  output logic              standby_o
);
  ctrl_t             ctrl_in, ctrl_s;
  logic [ADDR_W-1:0] addr_s, wr_addr;
  logic [DATA_W-1:0] data_s, wr_data, rd_data;
  logic [LANES-1:0]  wr_en;

  assign ctrl_in = '{ce_n: ce_ni, oe_n: oe_ni, we_n: we_ni, be_n: {ub_ni, lb_ni}};

  sram_bl_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl_in),
    .addr_i (addr_i),
    .data_i (data_i),
    .ctrl_o (ctrl_s),
    .addr_o (addr_s),
    .data_o (data_s)
  );

  sram_bl_write_ctl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_write (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ctrl_s.ce_n),
    .we_ni     (ctrl_s.we_n),
    .be_ni     (ctrl_s.be_n),
    .addr_i    (addr_s),
    .data_i    (data_s),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  sram_bl_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (addr_s),
    .rd_data_o (rd_data)
  );

  sram_bl_read_ctl #(.LANE_W(LANE_W)) u_read (
    .ctrl_i    (ctrl_s),
    .rd_data_i (rd_data),
    .data_o    (data_o),
    .drive_o   (drive_o),
    .standby_o (standby_o)
  );
endmodule

// File: rtl/sram_byte_lane_chk.sv
module sram_byte_lane_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       oe_ni,
  input logic       we_ni,
  input logic       lb_ni,
  input logic       ub_ni,
  input logic [1:0] drive_o,
  input logic       standby_o,
  input logic [1:0] wr_en_i
);
  AST_STANDBY_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || (lb_ni && ub_ni)) |=> standby_o); // R2
  AST_ACTIVE_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !(lb_ni && ub_ni)) |=> !standby_o); // R2
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> drive_o == 2'b00); // R2
  AST_COMMIT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[0] |-> ($past(!ce_ni && !we_ni && !lb_ni, 2) && !$past(!ce_ni && !we_ni && !lb_ni))); // R4
  AST_COMMIT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[1] |-> ($past(!ce_ni && !we_ni && !ub_ni, 2) && !$past(!ce_ni && !we_ni && !ub_ni))); // R5
  AST_READ_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && we_ni && !lb_ni) |=> drive_o[0]); // R6
  AST_READ_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && we_ni && !ub_ni) |=> drive_o[1]); // R6
  AST_LANE_OFF_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_ni |=> !drive_o[0]); // R3
  AST_LANE_OFF_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ub_ni |=> !drive_o[1]); // R3
  AST_OE_HIGH_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> drive_o == 2'b00); // R7
  AST_WE_LOW_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> drive_o == 2'b00); // R8
endmodule

bind sram_byte_lane sram_byte_lane_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .oe_ni     (oe_ni),
  .we_ni     (we_ni),
  .lb_ni     (lb_ni),
  .ub_ni     (ub_ni),
  .drive_o   (drive_o),
  .standby_o (standby_o),
  .wr_en_i   (wr_en)
);

// File: tb/sram_byte_lane_test.sv
module sram_byte_lane_test;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_ni;
  logic [ADDR_W-1:0] addr_i;
  logic              ce_ni, oe_ni, we_ni, lb_ni, ub_ni;
  logic [15:0]       data_i, data_o;
  logic [1:0]        drive_o;
  logic              standby_o;

  sram_byte_lane #(.ADDR_W(ADDR_W), .LANE_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .ce_ni(ce_ni), .oe_ni(oe_ni),
    .we_ni(we_ni), .lb_ni(lb_ni), .ub_ni(ub_ni), .data_i(data_i), .data_o(data_o),
    .drive_o(drive_o), .standby_o(standby_o)
  );

  logic [15:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] w, input logic lbn, input logic ubn);
    return {ubn ? 8'h00 : w[15:8], lbn ? 8'h00 : w[7:0]};
  endfunction

  task automatic set(input logic [ADDR_W-1:0] a, input logic ce, input logic oe,
                     input logic we, input logic lb, input logic ub, input logic [15:0] d);
    @(negedge clk);
    addr_i = a; ce_ni = ce; oe_ni = oe; we_ni = we; lb_ni = lb; ub_ni = ub; data_i = d;
  endtask

  task automatic idle();
    set(addr_i, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, data_i);
  endtask

  // m: bit0 = lower lane enabled, bit1 = upper lane enabled; kind 0 we, 1 ce, 2 lane enables
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                          input logic [1:0] m, input int kind, input logic oe);
    set(a, 1'b0, oe, 1'b1, ~m[0], ~m[1], d);
    set(a, 1'b0, oe, 1'b0, ~m[0], ~m[1], d);
    set(a, 1'b0, oe, 1'b0, ~m[0], ~m[1], d);
    case (kind)
      0:       set(a, 1'b0, oe, 1'b1, ~m[0], ~m[1], d);
      1:       set(a, 1'b1, oe, 1'b0, ~m[0], ~m[1], d);
      default: set(a, 1'b0, oe, 1'b0, 1'b1, 1'b1, d);
    endcase
    idle();
    idle();
    if (m[0]) model[a][7:0]  = d[7:0];
    if (m[1]) model[a][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic lbn, input logic ubn,
                         input string req);
    set(a, 1'b0, 1'b0, 1'b1, lbn, ubn, data_i);
    @(negedge clk);
    chk({req, " drive"}, {30'd0, drive_o}, {30'd0, ~ubn, ~lbn});
    chk({req, " data"}, {16'd0, data_o}, {16'd0, exp_read(model[a], lbn, ubn)});
    idle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0; addr_i = '0; ce_ni = 1'b1; oe_ni = 1'b1; we_ni = 1'b1;
    lb_ni = 1'b1; ub_ni = 1'b1; data_i = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset standby", {31'd0, standby_o}, 32'd1);
    chk("R2 reset drive", {30'd0, drive_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 post-reset standby", {31'd0, standby_o}, 32'd1);

    // R1: fill every word, ending by each signal in turn, then read all back
    for (int a = 0; a < DEPTH; a++)
      do_write(a[ADDR_W-1:0], 16'(a * 16'h9E37) ^ 16'h5A5A, 2'b11, a % 3, a[0]);
    for (int a = 0; a < DEPTH; a++) do_read(a[ADDR_W-1:0], 1'b0, 1'b0, "R1 fill");

    // R3: upper-only and lower-only writes leave the other lane alone
    do_write(10'd5, 16'hABCD, 2'b10, 0, 1'b1);
    do_read(10'd5, 1'b0, 1'b0, "R3 upper only");
    do_write(10'd6, 16'h1234, 2'b01, 1, 1'b0);
    do_read(10'd6, 1'b0, 1'b0, "R3 lower only");
    do_write(10'd8, 16'hFFFF, 2'b00, 0, 1'b1);
    do_read(10'd8, 1'b0, 1'b0, "R3 no lane");

    // R4: data changed inside the window, last value wins
    set(10'd20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1111);
    set(10'd20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1111);
    set(10'd20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2222);
    set(10'd20, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h3333);
    idle(); idle();
    model[20] = 16'h2222;
    do_read(10'd20, 1'b0, 1'b0, "R4 data moved");

    // R4: address moved inside the window, earlier address untouched
    set(10'd30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC0DE);
    set(10'd30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC0DE);
    set(10'd31, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC0DE);
    set(10'd31, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hC0DE);
    idle(); idle();
    model[31] = 16'hC0DE;
    do_read(10'd30, 1'b0, 1'b0, "R4 old address");
    do_read(10'd31, 1'b0, 1'b0, "R4 new address");

    // R5: upper lane closes first, lower closes later by write enable
    set(10'd40, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hA1B2);
    set(10'd40, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hA1B2);
    set(10'd40, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hC3D4);
    set(10'd40, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hC3D4);
    set(10'd40, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hC3D4);
    idle(); idle();
    model[40] = 16'hA1D4;
    do_read(10'd40, 1'b0, 1'b0, "R5 split lanes");

    // R8: window open with output enable low, bus stays undriven
    set(10'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7E57);
    @(negedge clk);
    chk("R8 we low drive", {30'd0, drive_o}, 32'd0);
    chk("R8 we low standby", {31'd0, standby_o}, 32'd0);
    set(10'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h7E57);
    idle(); idle();
    model[7] = 16'h7E57;
    do_read(10'd7, 1'b0, 1'b0, "R6 after oe-low write");

    // R2 / R7 decode
    set(10'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    chk("R2 ce high standby", {31'd0, standby_o}, 32'd1);
    chk("R2 ce high drive", {30'd0, drive_o}, 32'd0);
    set(10'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0);
    @(negedge clk);
    chk("R2 lanes off standby", {31'd0, standby_o}, 32'd1);
    chk("R2 lanes off data", {16'd0, data_o}, 32'd0);
    set(10'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    chk("R7 oe high drive", {30'd0, drive_o}, 32'd0);
    chk("R7 oe high standby", {31'd0, standby_o}, 32'd0);
    idle();

    // R6 single-lane reads
    do_read(10'd40, 1'b0, 1'b1, "R6 lower read");
    do_read(10'd40, 1'b1, 1'b0, "R6 upper read");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] ra;
      ra = ADDR_W'($urandom % 64);
      if ($urandom % 2 == 0)
        do_write(ra, 16'($urandom), 2'($urandom), int'($urandom % 3), 1'($urandom));
      else
        do_read(ra, 1'($urandom), 1'($urandom), "R6 random");
    end

    finish_run();
  end
endmodule